// File: doc/BRIEF.md
# Configurable I/O Port Pad Controller

This block is the digital control side of a general-purpose I/O port with eight pins by default. Software reaches it through a small synchronous register interface. There is one register each for direction, output data, open-drain selection, pull-up selection and analog mode, plus a read-only view of the pin levels. From these settings the block computes four pad control signals for every pin: output-buffer enable, driven value, pull-up enable and input-buffer enable.

Two peripherals can take over the upper pins. A synchronous serial interface uses two pins for bidirectional lines that are always open-drain. A UART uses one pin for transmit and one for receive. An enabled peripheral overrides the software settings that conflict with its use of the pin. The pull-up is gated automatically, so it is never on while a pin actively drives.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After synchronous reset, the direction, output, open-drain, pull-up and analog registers all read 0. With no peripheral enabled this gives: every `pad_oe` bit 0, every `pad_pullup_en` bit 0, every `pad_ie` bit 1.
- R2: A write with `wr_en` high updates the register at `addr` on the next rising clock edge. `rdata` shows the register at `addr` combinationally. The address map is: 0 direction, 1 output data, 2 open-drain, 3 pull-up, 4 analog mode, 5 pin view (read-only). A write to address 5 changes no register.
- R3: A pin with no peripheral override, open-drain bit 0 and direction bit 1 has `pad_oe`=1 and `pad_out` equal to its output-data bit. With direction bit 0 it has `pad_oe`=0.
- R4: With open-drain bit 1, `pad_out` is 0. `pad_oe` is 1 only while the direction bit is 1 and the effective output bit is 0.
- R5: `pad_pullup_en` equals the pin's pull-up bit when the pin is an input or a released open-drain output. Otherwise it is 0, so it is never 1 together with `pad_oe`.
- R6: A pin whose analog bit is 1 has `pad_ie`=0, and reads as 0 in the pin view. Otherwise `pad_ie`=1.
- R7: The pin view (address 5) shows `pad_in` in the same cycle, with no filtering, whatever the pin's direction.
- R8: While `ssi_en` is 1, pins 4 and 5 are open-drain whatever the registers hold. Pin 4 is driven or released according to `ssi_s0_drive`, with value `ssi_s0_val`; pin 5 likewise uses `ssi_s1_drive` and `ssi_s1_val`. `ssi_s0_in` and `ssi_s1_in` carry the pin-view values of pins 4 and 5.
- R9: While `uart_tx_en` is 1, pin 6 is an output carrying `uart_tx`, whatever its direction and output-data bits. Its open-drain bit still applies.
- R10: While `uart_rx_en` is 1, pin 7 is an input (`pad_oe`=0) and `uart_rx` carries its pin-view value. While it is 0, `uart_rx` is 1.
- R11: Reading an unmapped address (6 or 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | N_PINS | Write data |
| rdata | output | N_PINS | Combinational read data |
| pad_in | input | N_PINS | Pin levels from the pads |
| pad_oe | output | N_PINS | Output-buffer enable per pin |
| pad_out | output | N_PINS | Value driven per pin |
| pad_pullup_en | output | N_PINS | Pull-up enable per pin |
| pad_ie | output | N_PINS | Input-buffer enable per pin |
| ssi_en | input | 1 | Serial-interface pin takeover |
| ssi_s0_drive | input | 1 | Serial line 0 is driven (1) or released (0) |
| ssi_s1_drive | input | 1 | Serial line 1 is driven (1) or released (0) |
| ssi_s0_val | input | 1 | Serial line 0 output value |
| ssi_s1_val | input | 1 | Serial line 1 output value |
| ssi_s0_in | output | 1 | Serial line 0 pin value |
| ssi_s1_in | output | 1 | Serial line 1 pin value |
| uart_tx_en | input | 1 | UART transmit takeover of pin 6 |
| uart_tx | input | 1 | UART transmit data |
| uart_rx_en | input | 1 | UART receive takeover of pin 7 |
| uart_rx | output | 1 | UART receive data |

## Verification
The bench builds the block with its default parameters: eight pins, a three-bit address, and the serial lines on pins 4 and 5 with the UART on pins 6 and 7. This puts every override pin inside the register width. Each peripheral therefore competes with real direction, output and open-drain bits, and the full address space includes two unmapped addresses. Random combinations of enables, register contents and pad levels then reach the pull-up gating and analog masking on pins that are under peripheral control at the same moment.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
   // register slots; the configuration slots are contiguous from zero
   localparam int unsigned A_DIR  = 0;
   localparam int unsigned A_DOUT = 1;
   localparam int unsigned A_OD   = 2;
   localparam int unsigned A_PULL = 3;
   localparam int unsigned A_ANA  = 4;
   localparam int unsigned A_PIN  = 5;
   localparam int unsigned NUM_CFG = 5;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pad_pkg::*;
#(
   parameter int unsigned N_PINS = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [N_PINS-1:0] wdata,
   input  logic [N_PINS-1:0] pin_view,
   output logic [N_PINS-1:0] rdata,
   output logic [N_PINS-1:0] dir_q,
   output logic [N_PINS-1:0] dout_q,
   output logic [N_PINS-1:0] od_q,
   output logic [N_PINS-1:0] pull_q,
   output logic [N_PINS-1:0] ana_q
);
   logic [NUM_CFG-1:0][N_PINS-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < NUM_CFG; g++) begin
            if (addr == ADDR_W'(g)) cfg_q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NUM_CFG; g++) begin
         if (addr == ADDR_W'(g)) rdata = cfg_q[g];
      end
      if (addr == ADDR_W'(A_PIN)) rdata = pin_view;
   end

   assign dir_q  = cfg_q[A_DIR];
   assign dout_q = cfg_q[A_DOUT];
   assign od_q   = cfg_q[A_OD];
   assign pull_q = cfg_q[A_PULL];
   assign ana_q  = cfg_q[A_ANA];
endmodule

// File: rtl/gpio_periph_mux.sv
module gpio_periph_mux #(
   parameter int unsigned N_PINS     = 8,
   parameter int unsigned SSI_S0_PIN = 4,
   parameter int unsigned SSI_S1_PIN = 5,
   parameter int unsigned TX_PIN     = 6,
   parameter int unsigned RX_PIN     = 7
) (
   input  logic [N_PINS-1:0] dir_q,
   input  logic [N_PINS-1:0] dout_q,
   input  logic [N_PINS-1:0] od_q,
   input  logic [N_PINS-1:0] in_val,
   input  logic              ssi_en,
   input  logic              ssi_s0_drive,
   input  logic              ssi_s1_drive,
   input  logic              ssi_s0_val,
   input  logic              ssi_s1_val,
   input  logic              uart_tx_en,
   input  logic              uart_tx,
   input  logic              uart_rx_en,
   output logic [N_PINS-1:0] eff_dir,
   output logic [N_PINS-1:0] eff_out,
   output logic [N_PINS-1:0] eff_od,
   output logic              ssi_s0_in,
   output logic              ssi_s1_in,
   output logic              uart_rx
);
   always_comb begin
      eff_dir = dir_q;
      eff_out = dout_q;
      eff_od  = od_q;
      if (ssi_en) begin
         eff_od[SSI_S0_PIN]  = 1'b1;
         eff_od[SSI_S1_PIN]  = 1'b1;
         eff_dir[SSI_S0_PIN] = ssi_s0_drive;
         eff_dir[SSI_S1_PIN] = ssi_s1_drive;
         eff_out[SSI_S0_PIN] = ssi_s0_val;
         eff_out[SSI_S1_PIN] = ssi_s1_val;
      end
      if (uart_tx_en) begin
         eff_dir[TX_PIN] = 1'b1;
         eff_out[TX_PIN] = uart_tx;
      end
      if (uart_rx_en) begin
         eff_dir[RX_PIN] = 1'b0;
      end
   end

   assign ssi_s0_in = in_val[SSI_S0_PIN];
   assign ssi_s1_in = in_val[SSI_S1_PIN];
   assign uart_rx   = uart_rx_en ? in_val[RX_PIN] : 1'b1;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
   input  logic eff_dir,
   input  logic eff_out,
   input  logic eff_od,
   input  logic pull_sel,
   input  logic analog,
   input  logic pad_in,
   output logic pad_oe,
   output logic pad_out,
   output logic pad_pullup_en,
   output logic pad_ie,
   output logic in_val
);
   logic released;

   // an open-drain pin holding a 1 lets the line float
   assign released      = eff_od & eff_out;
   assign pad_oe        = eff_dir & ~released;
   assign pad_out       = eff_od ? 1'b0 : eff_out;
   assign pad_pullup_en = pull_sel & (~eff_dir | released);
   assign pad_ie        = ~analog;
   assign in_val        = analog ? 1'b0 : pad_in;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_pad_pkg::*;
#(
   parameter int unsigned N_PINS     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned SSI_S0_PIN = 4,
   parameter int unsigned SSI_S1_PIN = 5,
   parameter int unsigned TX_PIN     = 6,
   parameter int unsigned RX_PIN     = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [N_PINS-1:0] wdata,
   output logic [N_PINS-1:0] rdata,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_pullup_en,
   output logic [N_PINS-1:0] pad_ie,
   input  logic              ssi_en,
   input  logic              ssi_s0_drive,
   input  logic              ssi_s1_drive,
   input  logic              ssi_s0_val,
   input  logic              ssi_s1_val,
   output logic              ssi_s0_in,
   output logic              ssi_s1_in,
   input  logic              uart_tx_en,
   input  logic              uart_tx,
   input  logic              uart_rx_en,
   output logic              uart_rx
);
   localparam int unsigned MAX_PIN_IDX = N_PINS - 1;

   generate
      if ((1 << ADDR_W) <= A_PIN) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (SSI_S0_PIN > MAX_PIN_IDX || SSI_S1_PIN > MAX_PIN_IDX ||
          TX_PIN > MAX_PIN_IDX || RX_PIN > MAX_PIN_IDX) begin : g_bad_pin
         $error("peripheral pin index outside the port");
      end
      if (SSI_S0_PIN == SSI_S1_PIN || TX_PIN == RX_PIN ||
          TX_PIN == SSI_S0_PIN || TX_PIN == SSI_S1_PIN ||
          RX_PIN == SSI_S0_PIN || RX_PIN == SSI_S1_PIN) begin : g_bad_share
         $error("peripheral pins must be distinct");
      end
   endgenerate

   logic [N_PINS-1:0] dir_q, dout_q, od_q, pull_q, ana_q;
   logic [N_PINS-1:0] eff_dir, eff_out, eff_od, in_val;

   gpio_regfile #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .pin_view(in_val), .rdata(rdata),
      .dir_q(dir_q), .dout_q(dout_q), .od_q(od_q), .pull_q(pull_q), .ana_q(ana_q)
   );

   gpio_periph_mux #(
      .N_PINS(N_PINS), .SSI_S0_PIN(SSI_S0_PIN), .SSI_S1_PIN(SSI_S1_PIN),
      .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
   ) u_mux (
      .dir_q(dir_q), .dout_q(dout_q), .od_q(od_q), .in_val(in_val),
      .ssi_en(ssi_en), .ssi_s0_drive(ssi_s0_drive), .ssi_s1_drive(ssi_s1_drive),
      .ssi_s0_val(ssi_s0_val), .ssi_s1_val(ssi_s1_val),
      .uart_tx_en(uart_tx_en), .uart_tx(uart_tx), .uart_rx_en(uart_rx_en),
      .eff_dir(eff_dir), .eff_out(eff_out), .eff_od(eff_od),
      .ssi_s0_in(ssi_s0_in), .ssi_s1_in(ssi_s1_in), .uart_rx(uart_rx)
   );

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      gpio_pin_cell u_cell (
         .eff_dir(eff_dir[p]), .eff_out(eff_out[p]), .eff_od(eff_od[p]),
         .pull_sel(pull_q[p]), .analog(ana_q[p]), .pad_in(pad_in[p]),
         .pad_oe(pad_oe[p]), .pad_out(pad_out[p]),
         .pad_pullup_en(pad_pullup_en[p]), .pad_ie(pad_ie[p]), .in_val(in_val[p])
      );
   end
endmodule

// File: rtl/gpio_pad_ctrl_checker.sv
module gpio_pad_ctrl_checker
   import gpio_pad_pkg::*;
#(
   parameter int unsigned N_PINS     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned SSI_S0_PIN = 4,
   parameter int unsigned SSI_S1_PIN = 5,
   parameter int unsigned TX_PIN     = 6,
   parameter int unsigned RX_PIN     = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [N_PINS-1:0] wdata,
   input logic [N_PINS-1:0] rdata,
   input logic [N_PINS-1:0] pad_oe,
   input logic [N_PINS-1:0] pad_out,
   input logic [N_PINS-1:0] pad_pullup_en,
   input logic              ssi_en,
   input logic              ssi_s0_drive,
   input logic              ssi_s0_val,
   input logic              uart_tx_en,
   input logic              uart_tx,
   input logic              uart_rx_en,
   input logic [N_PINS-1:0] dir_q,
   input logic [N_PINS-1:0] od_q,
   input logic [N_PINS-1:0] ana_q
);
   localparam logic [N_PINS-1:0] PERIPH_MASK =
      (N_PINS'(1) << SSI_S0_PIN) | (N_PINS'(1) << SSI_S1_PIN) |
      (N_PINS'(1) << TX_PIN) | (N_PINS'(1) << RX_PIN);

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (dir_q == '0 && od_q == '0 && ana_q == '0));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(A_DIR)) |=> (dir_q == $past(wdata)));

   p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (rst)
      (pad_oe & ~dir_q & ~PERIPH_MASK) == '0);

   p_od_never_high_r4: assert property (@(posedge clk) disable iff (rst)
      (pad_oe & pad_out & od_q) == '0);

   p_pull_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
      (pad_pullup_en & pad_oe) == '0);

   p_analog_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (addr == ADDR_W'(A_PIN)) |-> ((rdata & ana_q) == '0));

   p_ssi_open_drain_r8: assert property (@(posedge clk) disable iff (rst)
      ssi_en |-> (!pad_out[SSI_S0_PIN] && !pad_out[SSI_S1_PIN] &&
                  pad_oe[SSI_S0_PIN] == (ssi_s0_drive && !ssi_s0_val)));

   p_tx_drives_r9: assert property (@(posedge clk) disable iff (rst)
      (uart_tx_en && !od_q[TX_PIN]) |-> (pad_oe[TX_PIN] && pad_out[TX_PIN] == uart_tx));

   p_rx_input_r10: assert property (@(posedge clk) disable iff (rst)
      uart_rx_en |-> !pad_oe[RX_PIN]);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_checker #(
   .N_PINS(N_PINS), .ADDR_W(ADDR_W), .SSI_S0_PIN(SSI_S0_PIN),
   .SSI_S1_PIN(SSI_S1_PIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
) u_chk (
   .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
   .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup_en(pad_pullup_en),
   .ssi_en(ssi_en), .ssi_s0_drive(ssi_s0_drive), .ssi_s0_val(ssi_s0_val),
   .uart_tx_en(uart_tx_en), .uart_tx(uart_tx), .uart_rx_en(uart_rx_en),
   .dir_q(dir_q), .od_q(od_q), .ana_q(ana_q)
);

// File: tb/gpio_pad_ctrl_bench.sv
`timescale 1ns/100ps
module gpio_pad_ctrl_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] addr = '0;
   logic wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, pad_oe, pad_out, pad_pullup_en, pad_ie;
   logic [7:0] pad_in = '0;
   logic ssi_en = 0, ssi_s0_drive = 0, ssi_s1_drive = 0, ssi_s0_val = 0, ssi_s1_val = 0;
   logic uart_tx_en = 0, uart_tx = 0, uart_rx_en = 0;
   logic ssi_s0_in, ssi_s1_in, uart_rx;

   int errors = 0;
   int checks = 0;
   bit cmp_on = 0;
   bit done = 0;

   // reference register state
   logic [7:0] m_dir = '0, m_dout = '0, m_od = '0, m_pull = '0, m_ana = '0;

   always #2.5 clk = ~clk;

   gpio_pad_ctrl u_gpio_pad_ctrl (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pullup_en(pad_pullup_en), .pad_ie(pad_ie),
      .ssi_en(ssi_en), .ssi_s0_drive(ssi_s0_drive), .ssi_s1_drive(ssi_s1_drive),
      .ssi_s0_val(ssi_s0_val), .ssi_s1_val(ssi_s1_val),
      .ssi_s0_in(ssi_s0_in), .ssi_s1_in(ssi_s1_in),
      .uart_tx_en(uart_tx_en), .uart_tx(uart_tx), .uart_rx_en(uart_rx_en), .uart_rx(uart_rx)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_dir = '0; m_dout = '0; m_od = '0; m_pull = '0; m_ana = '0;
      end else if (wr_en) begin
         case (addr)
            3'd0: m_dir = wdata;
            3'd1: m_dout = wdata;
            3'd2: m_od = wdata;
            3'd3: m_pull = wdata;
            3'd4: m_ana = wdata;
            default: ;
         endcase
      end
   end

   // cycle-by-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         logic [7:0] view;
         logic [7:0] exp_rd;
         view = pad_in & ~m_ana;
         for (int i = 0; i < 8; i++) begin
            bit d, o, od, drv, e_out, e_pu;
            string tg;
            d = m_dir[i]; o = m_dout[i]; od = m_od[i];
            tg = od ? "R4" : "R3";
            if (ssi_en && i == 4) begin d = ssi_s0_drive; o = ssi_s0_val; od = 1; tg = "R8"; end
            if (ssi_en && i == 5) begin d = ssi_s1_drive; o = ssi_s1_val; od = 1; tg = "R8"; end
            if (uart_tx_en && i == 6) begin d = 1; o = uart_tx; tg = "R9"; end
            if (uart_rx_en && i == 7) begin d = 0; tg = "R10"; end
            drv = d && !(od && o);
            e_out = od ? 1'b0 : o;
            e_pu = m_pull[i] && (!d || (od && o));
            check(pad_oe[i] == drv, tg, $sformatf("pad_oe[%0d]", i), pad_oe[i], drv);
            check(pad_out[i] == e_out, tg, $sformatf("pad_out[%0d]", i), pad_out[i], e_out);
            check(pad_pullup_en[i] == e_pu, "R5", $sformatf("pull[%0d]", i), pad_pullup_en[i], e_pu);
            check(pad_ie[i] == !m_ana[i], "R6", $sformatf("pad_ie[%0d]", i), pad_ie[i], !m_ana[i]);
         end
         case (addr)
            3'd0: exp_rd = m_dir;
            3'd1: exp_rd = m_dout;
            3'd2: exp_rd = m_od;
            3'd3: exp_rd = m_pull;
            3'd4: exp_rd = m_ana;
            3'd5: exp_rd = view;
            default: exp_rd = '0;
         endcase
         check(rdata == exp_rd, addr == 3'd5 ? "R7" : (addr > 3'd5 ? "R11" : "R2"),
               "rdata", rdata, exp_rd);
         check(uart_rx == (uart_rx_en ? view[7] : 1'b1), "R10", "uart_rx",
               uart_rx, uart_rx_en ? view[7] : 1'b1);
         check(ssi_s0_in == view[4] && ssi_s1_in == view[5], "R8", "ssi_in",
               {ssi_s1_in, ssi_s0_in}, view[5:4]);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
      addr = a;
      @(negedge clk);
      check(rdata == exp, tag, $sformatf("read addr %0d", a), rdata, exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      cmp_on = 1;
      @(negedge clk);
      // R1 reset state
      check(pad_oe == 8'h00, "R1", "pad_oe", pad_oe, 8'h00);
      check(pad_pullup_en == 8'h00, "R1", "pull", pad_pullup_en, 8'h00);
      check(pad_ie == 8'hFF, "R1", "pad_ie", pad_ie, 8'hFF);
      for (int a = 0; a < 5; a++) rd_check(3'(a), 8'h00, "R1");

      // R3 push-pull
      wr(3'd0, 8'hFF); wr(3'd1, 8'hA5);
      @(negedge clk);
      check(pad_oe == 8'hFF, "R3", "pad_oe", pad_oe, 8'hFF);
      check(pad_out == 8'hA5, "R3", "pad_out", pad_out, 8'hA5);
      // R4 open-drain, R5 pull-up on released lines
      wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      @(negedge clk);
      check(pad_oe == 8'h5A, "R4", "pad_oe", pad_oe, 8'h5A);
      check(pad_out == 8'h00, "R4", "pad_out", pad_out, 8'h00);
      check(pad_pullup_en == 8'hA5, "R5", "pull", pad_pullup_en, 8'hA5);
      wr(3'd2, 8'h00); wr(3'd0, 8'h0F);
      @(negedge clk);
      check(pad_pullup_en == 8'hF0, "R5", "pull", pad_pullup_en, 8'hF0);
      // R6 analog, R7 direct view while outputs
      wr(3'd0, 8'hFF); wr(3'd4, 8'h03);
      pad_in = 8'h3F;
      rd_check(3'd5, 8'h3C, "R6");
      check(pad_ie == 8'hFC, "R6", "pad_ie", pad_ie, 8'hFC);
      pad_in = 8'hC4;
      rd_check(3'd5, 8'hC4, "R7");
      // R2 write to read-only slot ignored, R11 unmapped
      wr(3'd5, 8'h00);
      rd_check(3'd1, 8'hA5, "R2");
      rd_check(3'd0, 8'hFF, "R2");
      rd_check(3'd6, 8'h00, "R11");
      rd_check(3'd7, 8'h00, "R11");
      // R8 serial takeover
      ssi_en = 1; ssi_s0_drive = 1; ssi_s0_val = 0; ssi_s1_drive = 1; ssi_s1_val = 1;
      @(negedge clk);
      check(pad_oe[5:4] == 2'b01, "R8", "pad_oe[5:4]", pad_oe[5:4], 2'b01);
      check(pad_out[5:4] == 2'b00, "R8", "pad_out[5:4]", pad_out[5:4], 2'b00);
      ssi_en = 0;
      // R9 transmit takeover with direction bit cleared
      wr(3'd0, 8'h00);
      uart_tx_en = 1; uart_tx = 1;
      @(negedge clk);
      check(pad_oe[6] && pad_out[6], "R9", "pin6", {pad_oe[6], pad_out[6]}, 2'b11);
      uart_tx_en = 0;
      // R10 receive takeover
      wr(3'd0, 8'hFF);
      uart_rx_en = 1; pad_in = 8'h00;
      @(negedge clk);
      check(!pad_oe[7] && !uart_rx, "R10", "pin7", {pad_oe[7], uart_rx}, 2'b00);
      uart_rx_en = 0;
      @(negedge clk);
      check(uart_rx == 1'b1, "R10", "uart_rx idle", uart_rx, 1);

      // random phase, compared every cycle by the model
      for (int n = 0; n < 3000; n++) begin
         @(posedge clk); #1;
         wr_en = ($urandom_range(0, 2) == 0);
         addr = 3'($urandom_range(0, 7));
         wdata = 8'($urandom);
         pad_in = 8'($urandom);
         {ssi_en, ssi_s0_drive, ssi_s1_drive, ssi_s0_val, ssi_s1_val} = 5'($urandom);
         {uart_tx_en, uart_tx, uart_rx_en} = 3'($urandom);
      end
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule